// File: doc/BRIEF.md
# Prioritised Address Window Translator

This block converts a local-bus address into a PCI bus address, a PCI cycle type and a rule for the two lowest address bits. It holds three programmable windows. Each window has a base register (local base address, size code, enable, prefetch attribute) and a map register (PCI base address, cycle type, low-bit rule). A lookup is presented on one port and the result appears one clock later.

Windows may overlap on purpose. The search runs from window 0 upward and the first enabled window that contains the address supplies the translation. Software uses this to enlarge window 0 so that it covers window 1, reprogram window 1 as a configuration aperture, and shrink window 0 again afterwards. A lock guards the window registers: at reset they are locked and only a 16-bit key written to the system register opens them.

Window 2 is meant for PCI I/O and always spans 16 MB, whatever its size code says. For a configuration window, the high bits of the map register are added above the in-window offset, which lets device-select bits beyond the 16 MB local window be driven from the map register.

Top module: `addr_win_xlate`

## Requirements
- R1: After reset all three windows are disabled and the registers are locked, so every lookup misses and `res_valid` is low until a lookup is issued.
- R2: `wr_sel` 7 is the system register. Writing it with `wr_data[15:0]` = 0xA05F unlocks; writing it with any other value that has bit 15 set locks. While locked, writes to `wr_sel` 0..6 have no effect.
- R3: Window registers: `wr_sel` 0..2 is the base register of window 0..2 (`[31:20]` base in 1 MB units, `[5:4]` size code, `[1]` prefetch, `[0]` enable); `wr_sel` 4..6 is the map register of window 0..2 (`[31:20]` PCI base in 1 MB units, `[3:1]` cycle type, `[0]` low-bit pass). An enabled window hits when base <= address < base + size, with size codes 0/1/2/3 = 1/16/256/512 MB for windows 0 and 1; window 2 always spans 16 MB.
- R4: On a hit, `res_addr` = (address - window base) + map base, modulo 2^32.
- R5: When several enabled windows contain the address, the lowest-numbered one supplies the result, and `res_win` reports its index.
- R6: On a miss `res_hit`, `res_win`, `res_addr`, `res_ctype`, `res_low_en` and `res_pref` are all zero.
- R7: With the low-bit pass bit 0, `res_addr[1:0]` is forced to 00; with it 1, `res_addr[1:0]` equals the local address bits 1:0.
- R8: On a hit `res_ctype`, `res_low_en` and `res_pref` come from the winning window's map and base registers (cycle type 101 marks a configuration cycle, 011 memory, 110 prefetchable memory, 001 I/O).
- R9: The result appears with `res_valid` high exactly one cycle after `lk_valid`; a lookup issued in the same cycle as a register write uses the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (0..2 base, 4..6 map, 7 system) |
| wr_data | input | 32 | Register write data |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Local-bus address to translate |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_hit | output | 1 | A window matched |
| res_win | output | 2 | Index of the winning window |
| res_addr | output | 32 | Translated PCI address |
| res_ctype | output | 3 | PCI cycle type of the winning window |
| res_low_en | output | 1 | Low address bits passed from the local address |
| res_pref | output | 1 | Prefetch attribute of the winning window |

## Verification
A corrupted base, size or enable field shows on the very next lookup into the affected range as a wrong hit flag or a wrong window index, so boundary addresses on both sides of each window are probed. A wrong map field shows as a wrong address, cycle type or low-bit rule on the first hit of that window. A lock that opens or closes at the wrong time stays invisible until a later window write is or is not applied, so every lock change is followed by a write and a lookup that exposes it. Priority errors appear only while windows overlap, which the bench creates by enlarging window 0 over window 1.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    localparam int ADDR_W  = 32;
    localparam int GRAN_W  = 20;              // 1 MB granule
    localparam int HI_W    = ADDR_W - GRAN_W;
    localparam int NWIN    = 3;
    localparam int WIN_W   = $clog2(NWIN);
    localparam int IO_WIN  = 2;
    localparam int IO_LG   = 24;              // fixed 16 MB for the I/O window
    localparam int SEL_W   = 3;
    localparam logic [SEL_W-1:0] SEL_SYS = 3'd7;
    localparam logic [15:0] UNLOCK_KEY   = 16'hA05F;
    localparam int LOCK_BIT = 15;

    typedef struct packed {
        logic [HI_W-1:0] base_hi;
        logic [1:0]      size;
        logic            pref;
        logic            en;
    } win_base_t;

    typedef struct packed {
        logic [HI_W-1:0] pci_hi;
        logic [2:0]      ctype;
        logic            low_en;
    } win_map_t;

    typedef struct packed {
        logic              hit;
        logic [WIN_W-1:0]  win;
        logic [ADDR_W-1:0] addr;
        logic [2:0]        ctype;
        logic              low_en;
        logic              pref;
    } xlate_res_t;

    function automatic int size_lg(input logic [1:0] code);
        case (code)
            2'd0:    return 20;
            2'd1:    return 24;
            2'd2:    return 28;
            default: return 29;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] lg_mask(input int lg);
        logic [63:0] one;
        one = 64'd1 << lg;
        return ADDR_W'(one - 64'd1);
    endfunction
endpackage

// File: rtl/xlate_regs.sv
module xlate_regs
    import xlate_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [ADDR_W-1:0]    wr_data,
    output win_base_t [NWIN-1:0] base_q,
    output win_map_t  [NWIN-1:0] map_q,
    output logic                 locked
);
    logic [1:0] idx;
    logic       is_map;
    logic       unused_bits;

    assign idx    = wr_sel[1:0];
    assign is_map = wr_sel[2];
    assign unused_bits = ^{wr_data[19:16], wr_data[3:2]};

    always_ff @(posedge clk) begin
        if (rst) begin
            locked <= 1'b1;
            for (int i = 0; i < NWIN; i++) begin
                base_q[i] <= '0;
                map_q[i]  <= '0;
            end
        end else if (wr_en) begin
            if (wr_sel == SEL_SYS) begin
                if (wr_data[15:0] == UNLOCK_KEY)
                    locked <= 1'b0;
                else if (wr_data[LOCK_BIT])
                    locked <= 1'b1;
            end else if (!locked) begin
                for (int i = 0; i < NWIN; i++) begin
                    if (idx == 2'(i)) begin
                        if (is_map) begin
                            map_q[i].pci_hi <= wr_data[ADDR_W-1:GRAN_W];
                            map_q[i].ctype  <= wr_data[3:1];
                            map_q[i].low_en <= wr_data[0];
                        end else begin
                            base_q[i].base_hi <= wr_data[ADDR_W-1:GRAN_W];
                            base_q[i].size    <= wr_data[5:4];
                            base_q[i].pref    <= wr_data[1];
                            base_q[i].en      <= wr_data[0];
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/xlate_win_match.sv
module xlate_win_match
    import xlate_pkg::*;
#(
    parameter int FIXED_LG = 0     // 0: size from code, else fixed log2 size
) (
    input  logic [ADDR_W-1:0] addr,
    input  win_base_t         base,
    input  win_map_t          map,
    output logic              hit,
    output logic [ADDR_W-1:0] xaddr
);
    logic [ADDR_W-1:0] base_a, map_a, mask, diff;
    logic              borrow;

    always_comb begin
        base_a = {base.base_hi, {GRAN_W{1'b0}}};
        map_a  = {map.pci_hi, {GRAN_W{1'b0}}};
        if (FIXED_LG != 0)
            mask = lg_mask(FIXED_LG);
        else
            mask = lg_mask(size_lg(base.size));
        {borrow, diff} = {1'b0, addr} - {1'b0, base_a};
        hit   = base.en && !borrow && ((diff & ~mask) == '0);
        xaddr = (diff & mask) + map_a;
        if (!map.low_en)
            xaddr[1:0] = 2'b00;
    end
endmodule

// File: rtl/xlate_prio.sv
module xlate_prio
    import xlate_pkg::*;
(
    input  logic [NWIN-1:0]              hit,
    input  logic [NWIN-1:0][ADDR_W-1:0]  xaddr,
    input  win_base_t [NWIN-1:0]         base_q,
    input  win_map_t  [NWIN-1:0]         map_q,
    output xlate_res_t                   res
);
    always_comb begin
        res = '0;
        // scan downward so the lowest-numbered hit is the last to write
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (hit[i]) begin
                res.hit    = 1'b1;
                res.win    = WIN_W'(i);
                res.addr   = xaddr[i];
                res.ctype  = map_q[i].ctype;
                res.low_en = map_q[i].low_en;
                res.pref   = base_q[i].pref;
            end
        end
    end
endmodule

// File: rtl/addr_win_xlate.sv
module addr_win_xlate
    import xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [31:0]       wr_data,
    input  logic              lk_valid,
    input  logic [31:0]       lk_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic [1:0]        res_win,
    output logic [31:0]       res_addr,
    output logic [2:0]        res_ctype,
    output logic              res_low_en,
    output logic              res_pref
);
    win_base_t [NWIN-1:0]         base_q;
    win_map_t  [NWIN-1:0]         map_q;
    logic                         locked;
    logic [NWIN-1:0]              hit;
    logic [NWIN-1:0][ADDR_W-1:0]  xaddr;
    xlate_res_t                   res_c, res_q;
    logic                         vld_q;

    xlate_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .base_q(base_q), .map_q(map_q), .locked(locked)
    );

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        localparam int LG = (g == IO_WIN) ? IO_LG : 0;
        xlate_win_match #(.FIXED_LG(LG)) u_match (
            .addr(lk_addr), .base(base_q[g]), .map(map_q[g]),
            .hit(hit[g]), .xaddr(xaddr[g])
        );
    end

    xlate_prio u_prio (
        .hit(hit), .xaddr(xaddr), .base_q(base_q), .map_q(map_q), .res(res_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= lk_valid;
            if (lk_valid)
                res_q <= res_c;
        end
    end

    assign res_valid  = vld_q;
    assign res_hit    = res_q.hit;
    assign res_win    = res_q.win;
    assign res_addr   = res_q.addr;
    assign res_ctype  = res_q.ctype;
    assign res_low_en = res_q.low_en;
    assign res_pref   = res_q.pref;
endmodule

// File: rtl/xlate_chk.sv
module xlate_chk
    import xlate_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic [2:0]           wr_sel,
    input logic [31:0]          wr_data,
    input logic                 lk_valid,
    input logic [31:0]          lk_addr,
    input logic                 res_valid,
    input logic                 res_hit,
    input logic [1:0]           res_win,
    input logic [31:0]          res_addr,
    input logic [2:0]           res_ctype,
    input logic                 res_low_en,
    input logic                 res_pref,
    input logic                 locked,
    input win_base_t [NWIN-1:0] base_q,
    input win_map_t  [NWIN-1:0] map_q
);
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> res_valid);
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !res_valid);
    a_r6_miss_zero: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_hit) |-> (res_addr == '0 && res_ctype == '0 &&
                                     res_win == '0 && !res_low_en && !res_pref));
    a_r7_low_forced: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_hit && !res_low_en) |-> (res_addr[1:0] == 2'b00));
    a_r7_low_pass: assert property (@(posedge clk) disable iff (rst)
        (lk_valid) |=> (!(res_hit && res_low_en) || res_addr[1:0] == $past(lk_addr[1:0])));
    a_r2_locked_hold: assert property (@(posedge clk) disable iff (rst)
        (locked && wr_en && wr_sel != SEL_SYS) |=> ($stable(base_q) && $stable(map_q)));
    a_r2_key_unlocks: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_SYS && wr_data[15:0] == UNLOCK_KEY) |=> !locked);
    a_r5_win_range: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_hit) |-> (int'(res_win) < NWIN));

    logic unused_chk;
    assign unused_chk = ^{res_ctype, res_pref};
endmodule

bind addr_win_xlate xlate_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .res_valid(res_valid),
    .res_hit(res_hit), .res_win(res_win), .res_addr(res_addr),
    .res_ctype(res_ctype), .res_low_en(res_low_en), .res_pref(res_pref),
    .locked(locked), .base_q(base_q), .map_q(map_q)
);

// File: tb/tb_addr_win_xlate.sv
`timescale 1ns/1ps
module tb_addr_win_xlate;
    logic        clk = 0, rst = 1;
    logic        wr_en = 0;
    logic [2:0]  wr_sel = 0;
    logic [31:0] wr_data = 0;
    logic        lk_valid = 0;
    logic [31:0] lk_addr = 0;
    logic        res_valid, res_hit, res_low_en, res_pref;
    logic [1:0]  res_win;
    logic [31:0] res_addr;
    logic [2:0]  res_ctype;

    always #2.5 clk = ~clk;

    addr_win_xlate dut (.*);

    int tests = 0, fails = 0;
    bit done = 0;

    // bench model of the programmed state
    logic [11:0] m_base[3], m_phi[3];
    logic [1:0]  m_size[3];
    logic        m_en[3], m_pref[3], m_low[3];
    logic [2:0]  m_ct[3];
    logic        m_lock;

    typedef struct {
        logic        hit;
        logic [1:0]  win;
        logic [31:0] addr;
        logic [2:0]  ct;
        logic        low;
        logic        pref;
    } exp_t;

    exp_t  q_exp[$];
    string q_tag[$];

    function automatic exp_t model(input logic [31:0] a);
        exp_t e;
        longint sz, b;
        e = '{hit:0, win:0, addr:0, ct:0, low:0, pref:0};
        for (int i = 0; i < 3; i++) begin
            if (i == 2) sz = 64'd1 << 24;
            else case (m_size[i])
                2'd0: sz = 64'd1 << 20;
                2'd1: sz = 64'd1 << 24;
                2'd2: sz = 64'd1 << 28;
                default: sz = 64'd1 << 29;
            endcase
            b = longint'({m_base[i], 20'h0});
            if (!e.hit && m_en[i] && longint'(a) >= b && longint'(a) < b + sz) begin
                e.hit  = 1;
                e.win  = 2'(i);
                e.addr = 32'(longint'(a) - b + longint'({m_phi[i], 20'h0}));
                if (!m_low[i]) e.addr[1:0] = 2'b00;
                e.ct   = m_ct[i];
                e.low  = m_low[i];
                e.pref = m_pref[i];
            end
        end
        return e;
    endfunction

    task automatic model_write(input logic [2:0] s, input logic [31:0] d);
        if (s == 3'd7) begin
            if (d[15:0] == 16'hA05F) m_lock = 0;
            else if (d[15]) m_lock = 1;
        end else if (!m_lock && s[1:0] < 2'd3) begin
            if (s[2]) begin
                m_phi[s[1:0]] = d[31:20]; m_ct[s[1:0]] = d[3:1]; m_low[s[1:0]] = d[0];
            end else begin
                m_base[s[1:0]] = d[31:20]; m_size[s[1:0]] = d[5:4];
                m_pref[s[1:0]] = d[1];     m_en[s[1:0]]   = d[0];
            end
        end
    endtask

    // driver: one cycle per call, optional write and optional lookup
    task automatic cyc(input bit dw, input logic [2:0] s, input logic [31:0] d,
                       input bit dl, input logic [31:0] a, input string tag);
        @(negedge clk);
        wr_en = dw; wr_sel = s; wr_data = d;
        lk_valid = dl; lk_addr = a;
        if (dl) begin
            q_exp.push_back(model(a));
            q_tag.push_back(tag);
        end
        if (dw) model_write(s, d);
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        cyc(1, s, d, 0, 0, "");
    endtask

    task automatic lk(input logic [31:0] a, input string tag);
        cyc(0, 0, 0, 1, a, tag);
    endtask

    // monitor: compare results as they appear
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            exp_t e;
            string t;
            tests++;
            if (q_exp.size() == 0) begin
                fails++;
                $display("FAIL R9: unexpected result, actual valid=1 expected valid=0");
            end else begin
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                if (res_hit !== e.hit || res_win !== e.win || res_addr !== e.addr ||
                    res_ctype !== e.ct || res_low_en !== e.low || res_pref !== e.pref) begin
                    fails++;
                    $display("FAIL %s: actual hit=%0b win=%0d addr=%h ct=%b low=%0b pref=%0b expected hit=%0b win=%0d addr=%h ct=%b low=%0b pref=%0b",
                             t, res_hit, res_win, res_addr, res_ctype, res_low_en, res_pref,
                             e.hit, e.win, e.addr, e.ct, e.low, e.pref);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) begin
            m_base[i] = 0; m_phi[i] = 0; m_size[i] = 0; m_en[i] = 0;
            m_pref[i] = 0; m_low[i] = 0; m_ct[i] = 0;
        end
        m_lock = 1;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state at the ports
        tests++;
        if (res_valid !== 0 || res_hit !== 0) begin
            fails++;
            $display("FAIL R1: actual valid=%0b hit=%0b expected 0 0", res_valid, res_hit);
        end
        lk(32'h4000_0000, "R1");
        // R2: writes ignored while locked
        wr(3'd0, 32'h4000_0021);
        wr(3'd4, 32'h0000_0006);
        lk(32'h4000_0010, "R2");
        // unlock and program window 0 (256 MB memory)
        wr(3'd7, 32'h0000_A05F);
        wr(3'd0, 32'h4000_0021);
        wr(3'd4, 32'h0000_0006);
        lk(32'h4123_4567, "R4");
        lk(32'h4FFF_FFFC, "R3");
        lk(32'h3FFF_FFFC, "R3");
        // window 1: 256 MB prefetchable
        wr(3'd1, 32'h5000_0023);
        wr(3'd5, 32'h1000_000C);
        lk(32'h5000_0008, "R8");
        lk(32'h5FFF_FFFF, "R7");
        lk(32'h6000_0000, "R6");
        // window 2: I/O, size code ignored, low bits passed
        wr(3'd2, 32'h6000_0031);
        wr(3'd6, 32'h0000_0003);
        lk(32'h60FF_FFFF, "R7");
        lk(32'h6100_0000, "R3");
        // R5: enlarge window 0 to 512 MB, it hides window 1
        wr(3'd0, 32'h4000_0031);
        lk(32'h5000_0008, "R5");
        // window 1 becomes a 16 MB configuration aperture with high map bits
        wr(3'd1, 32'h6100_0011);
        wr(3'd5, 32'h0800_000A);
        lk(32'h6100_0A07, "R8");
        wr(3'd5, 32'h0800_000B);
        lk(32'h6100_0A07, "R7");
        // R9: lookup in the same cycle as a write sees old values
        cyc(1, 3'd0, 32'h0000_0000, 1, 32'h4000_0100, "R9");
        lk(32'h4000_0100, "R9");
        // R2: relock, then writes have no effect
        wr(3'd7, 32'h0000_8000);
        wr(3'd1, 32'h0000_0000);
        lk(32'h6100_0A04, "R2");
        wr(3'd7, 32'h0000_9234);
        wr(3'd1, 32'h0000_0000);
        lk(32'h6100_0A04, "R2");
        // R3: 1 MB window after unlocking
        wr(3'd7, 32'h0000_A05F);
        wr(3'd1, 32'h7000_0001);
        lk(32'h700F_FFF0, "R3");
        lk(32'h7010_0000, "R3");
        cyc(0, 0, 0, 0, 0, "");
        repeat (3) @(negedge clk);
        if (q_exp.size() != 0) begin
            tests++; fails++;
            $display("FAIL R9: actual %0d results missing expected 0", q_exp.size());
        end
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL R9: watchdog expired, actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule